// File: doc/BRIEF.md
# Sequence-Recall Reaction Tester

This controller runs a short memory-and-reaction challenge. On a start pulse it draws a pseudo-random string of hexadecimal digits whose length is itself random. It places the string in a display buffer with the show flag raised. After a fixed number of millisecond ticks it blanks the buffer. It then accepts digits from a hex keypad and compares each one with the stored string. Once the user has typed as many digits as the string holds, it judges the whole attempt.

A matching attempt raises a result flag and reports the user's reaction time in milliseconds. The time runs from the moment the string was blanked to the final keystroke. A wrong attempt discards the string and presents a freshly drawn one. After the permitted number of consecutive wrong attempts the controller raises an alarm. The controller holds either outcome until the next start pulse.

The random source is a congruential generator whose cycle is exactly 19683 states. It steps on every clock, so the moment of the start pulse also shapes the pattern. Character-display driving and keypad matrix scanning belong to neighbouring blocks.

Top module: `recall_tester`

## Requirements
- R1: After reset the show flag, the display digits and length, the result flag and the alarm are all low. Until a start pulse arrives, key strobes change none of them.
- R2: Each challenge has a length from MIN_LEN (6) to MAX_LEN (12), reported on `disp_len`. Digit k, where k=0 is the first to be typed, sits at `disp_digits[4k+3:4k]`. Slots at or above the length read zero.
- R3: The pattern stays shown for exactly SHOW_MS (2000) millisecond ticks, counted from the cycle after it appears. While blanked, the digits and the length read zero.
- R4: Key strobes are ignored outside the entry phase: while generating, while the pattern is shown, after a match and during the alarm.
- R5: An attempt is judged only on the accepted digit whose count equals the length. A match raises `result_valid`. The flag and `result_ms` then stay unchanged until a start pulse.
- R6: `result_ms` equals the number of cycles with `ms_tick` high after the blanking cycle, up to and including the cycle of the final digit. It saturates at 2^TIME_W-1 rather than wrapping.
- R7: An attempt in which any digit differs, with attempts remaining, gives no result and no alarm. A new pattern is then generated and shown.
- R8: The MAX_TRIES-th (3rd) consecutive mismatch raises `alarm`. The alarm holds, and no further pattern is shown until a start pulse.
- R9: A start pulse in any state clears the result, the alarm and the attempt count, and begins a new challenge. It takes priority over a digit strobed in the same cycle.
- R10: The random source steps every clock through a cycle of exactly 19683 states, so successive patterns differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle pulse that begins a new challenge |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| key_valid | input | 1 | Keypad digit strobe |
| key_digit | input | 4 | Keypad digit value |
| disp_digits | output | MAX_LEN*4 | Pattern buffer, first digit in the low nibble, zero while blanked |
| disp_len | output | $clog2(MAX_LEN+1) | Pattern length, zero while blanked |
| disp_show | output | 1 | High while the pattern is displayed |
| result_valid | output | 1 | High after a matching attempt |
| result_ms | output | TIME_W | Reaction time in milliseconds |
| alarm | output | 1 | High after the final allowed mismatch |

## Verification
A millisecond tick can land in the same cycle as the final keystroke. The design must count that tick in the reported time. The bench provokes this case by waiting until its tick schedule puts a tick on the next cycle, then strobing the last digit in that cycle. It judges `result_ms` against its own count of the ticks it drove after it saw the blank. The bench also strobes the final digit in the same cycle as a start pulse, and then expects no result and a fresh pattern.

// File: rtl/rt_pkg.sv
package rt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GEN, ST_SHOW, ST_ENTRY, ST_PASS, ST_ALARM
  } tst_state_e;

  // Congruential step: multiplier 7, increment 5, modulus = period.
  // Full period when period is a power of three (7-1 divisible by 3, 5 coprime).
  function automatic int unsigned lcg_next(int unsigned x, int unsigned period);
    return (x * 32'd7 + 32'd5) % period;
  endfunction

  function automatic int unsigned pick_len(int unsigned x, int unsigned minl,
                                           int unsigned maxl);
    return minl + ((x >> 6) % (maxl - minl + 32'd1));
  endfunction

  function automatic int unsigned pick_digit(int unsigned x);
    return (x ^ (x >> 8)) & 32'd15;
  endfunction

  function automatic logic [31:0] sat_inc(logic [31:0] v, logic inc, logic [31:0] top);
    if (inc && (v < top)) return v + 32'd1;
    return v;
  endfunction

endpackage

// File: rtl/rt_prng.sv
module rt_prng #(
  parameter int PERIOD = 19683,
  parameter int SEED   = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  output logic [$clog2(PERIOD)-1:0] state_o
);
  localparam int STW = $clog2(PERIOD);

  logic [STW-1:0] st_q;
  logic [STW-1:0] st_nxt;

  always_comb st_nxt = STW'(rt_pkg::lcg_next(32'(st_q), PERIOD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= STW'(SEED);
    else        st_q <= st_nxt;
  end

  assign state_o = st_q;

  // Checker counter: steps alongside the generator, wraps at PERIOD.
  logic [STW-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           cyc_q <= '0;
    else if (cyc_q == STW'(PERIOD - 1))   cyc_q <= '0;
    else                                  cyc_q <= cyc_q + 1'b1;
  end

  a_r10_period : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == STW'(SEED)) == (cyc_q == '0));
  a_r10_range : assert property (@(posedge clk) disable iff (!rst_n)
    st_q < STW'(PERIOD));

endmodule

// File: rtl/rt_pattern.sv
module rt_pattern #(
  parameter int MAX_LEN = 12,
  parameter int LEN_W   = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [LEN_W-1:0]       wr_idx,
  input  logic [3:0]             wr_digit,
  input  logic                   len_en,
  input  logic [LEN_W-1:0]       len_in,
  input  logic [LEN_W-1:0]       rd_idx,
  output logic [3:0]             rd_digit,
  output logic [LEN_W-1:0]       len_o,
  output logic [MAX_LEN*4-1:0]   flat_o
);
  logic [3:0]       slot_q [MAX_LEN];
  logic [LEN_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_en) len_q <= len_in;
  end

  for (genvar g = 0; g < MAX_LEN; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   slot_q[g] <= 4'h0;
      else if (wr_en && (wr_idx == LEN_W'(g)))      slot_q[g] <= wr_digit;
    end
    assign flat_o[g*4 +: 4] = (LEN_W'(g) < len_q) ? slot_q[g] : 4'h0;
  end

  assign rd_digit = slot_q[rd_idx];
  assign len_o    = len_q;

endmodule

// File: rtl/rt_ms_timer.sv
module rt_ms_timer #(
  parameter int SHOW_MS = 2000,
  parameter int TIME_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ms_tick,
  input  logic              show_run,
  input  logic              react_run,
  output logic              show_done,
  output logic [TIME_W-1:0] react_now
);
  localparam int SCW = $clog2(SHOW_MS + 1);

  logic [SCW-1:0]    show_cnt_q;
  logic [TIME_W-1:0] react_q;

  assign show_done = show_run && ms_tick && (show_cnt_q == SCW'(SHOW_MS - 1));
  assign react_now = TIME_W'(rt_pkg::sat_inc(32'(react_q), ms_tick,
                                             32'({TIME_W{1'b1}})));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      show_cnt_q <= '0;
      react_q    <= '0;
    end else begin
      show_cnt_q <= show_run  ? show_cnt_q + SCW'(ms_tick) : '0;
      react_q    <= react_run ? react_now : '0;
    end
  end

  a_r3_show_bound : assert property (@(posedge clk) disable iff (!rst_n)
    show_run |-> (show_cnt_q < SCW'(SHOW_MS)));
  a_r6_no_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    (react_run && (react_q == {TIME_W{1'b1}})) |=> (react_q == {TIME_W{1'b1}}));
  a_r6_unit_step : assert property (@(posedge clk) disable iff (!rst_n)
    react_run |=> ((react_q == $past(react_q)) || (react_q == $past(react_q) + 1'b1)));

endmodule

// File: rtl/recall_tester.sv
module recall_tester #(
  parameter int MIN_LEN     = 6,
  parameter int MAX_LEN     = 12,
  parameter int SHOW_MS     = 2000,
  parameter int MAX_TRIES   = 3,
  parameter int TIME_W      = 16,
  parameter int PRNG_PERIOD = 19683,
  parameter int PRNG_SEED   = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_req,
  input  logic                         ms_tick,
  input  logic                         key_valid,
  input  logic [3:0]                   key_digit,
  output logic [MAX_LEN*4-1:0]         disp_digits,
  output logic [$clog2(MAX_LEN+1)-1:0] disp_len,
  output logic                         disp_show,
  output logic                         result_valid,
  output logic [TIME_W-1:0]            result_ms,
  output logic                         alarm
);
  import rt_pkg::*;

  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int TRY_W = $clog2(MAX_TRIES + 1);
  localparam int STW   = $clog2(PRNG_PERIOD);

  tst_state_e        st_q;
  logic [LEN_W-1:0]  gen_idx_q, key_idx_q;
  logic [TRY_W-1:0]  tries_q;
  logic              miss_q, res_v_q, alarm_q;
  logic [TIME_W-1:0] result_q;

  logic [STW-1:0]       rnd;
  logic [3:0]           rd_digit, gen_digit;
  logic [LEN_W-1:0]     pat_len, gen_len;
  logic [MAX_LEN*4-1:0] pat_flat;
  logic [TIME_W-1:0]    react_now;

  // Named internal events
  logic gen_we, gen_first, gen_last, show_run, react_run, show_done;
  logic key_take, digit_eq, key_last, entry_ok, entry_bad, out_of_tries;

  assign gen_we       = (st_q == ST_GEN);
  assign gen_first    = gen_we && (gen_idx_q == '0);
  assign gen_last     = gen_we && (gen_idx_q == LEN_W'(MAX_LEN - 1));
  assign show_run     = (st_q == ST_SHOW);
  assign react_run    = (st_q == ST_ENTRY);
  assign key_take     = react_run && key_valid && !start_req;
  assign digit_eq     = (rd_digit == key_digit);
  assign key_last     = key_take && (key_idx_q == pat_len - 1'b1);
  assign entry_ok     = key_last && !miss_q && digit_eq;
  assign entry_bad    = key_last && !entry_ok;
  assign out_of_tries = entry_bad && (tries_q == TRY_W'(MAX_TRIES - 1));

  assign gen_digit = 4'(pick_digit(32'(rnd)));
  assign gen_len   = LEN_W'(pick_len(32'(rnd), MIN_LEN, MAX_LEN));

  rt_prng #(.PERIOD(PRNG_PERIOD), .SEED(PRNG_SEED)) prng_i (
    .clk(clk), .rst_n(rst_n), .state_o(rnd)
  );

  rt_pattern #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) pat_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(gen_we), .wr_idx(gen_idx_q), .wr_digit(gen_digit),
    .len_en(gen_first), .len_in(gen_len),
    .rd_idx(key_idx_q), .rd_digit(rd_digit),
    .len_o(pat_len), .flat_o(pat_flat)
  );

  rt_ms_timer #(.SHOW_MS(SHOW_MS), .TIME_W(TIME_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
    .show_run(show_run), .react_run(react_run),
    .show_done(show_done), .react_now(react_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      gen_idx_q <= '0;
      key_idx_q <= '0;
      tries_q   <= '0;
      miss_q    <= 1'b0;
      res_v_q   <= 1'b0;
      alarm_q   <= 1'b0;
      result_q  <= '0;
    end else if (start_req) begin
      st_q      <= ST_GEN;
      gen_idx_q <= '0;
      tries_q   <= '0;
      res_v_q   <= 1'b0;
      alarm_q   <= 1'b0;
      result_q  <= '0;
    end else begin
      unique case (st_q)
        ST_GEN: begin
          gen_idx_q <= gen_idx_q + 1'b1;
          key_idx_q <= '0;
          miss_q    <= 1'b0;
          if (gen_last) st_q <= ST_SHOW;
        end
        ST_SHOW: if (show_done) st_q <= ST_ENTRY;
        ST_ENTRY: if (key_take) begin
          key_idx_q <= key_idx_q + 1'b1;
          miss_q    <= miss_q | !digit_eq;
          if (entry_ok) begin
            st_q     <= ST_PASS;
            res_v_q  <= 1'b1;
            result_q <= react_now;
          end else if (out_of_tries) begin
            st_q    <= ST_ALARM;
            alarm_q <= 1'b1;
            tries_q <= tries_q + 1'b1;
          end else if (entry_bad) begin
            st_q      <= ST_GEN;
            gen_idx_q <= '0;
            tries_q   <= tries_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign disp_show    = show_run;
  assign disp_digits  = show_run ? pat_flat : '0;
  assign disp_len     = show_run ? pat_len : '0;
  assign result_valid = res_v_q;
  assign result_ms    = result_q;
  assign alarm        = alarm_q;

  a_r2_len_range : assert property (@(posedge clk) disable iff (!rst_n)
    disp_show |-> ((disp_len >= LEN_W'(MIN_LEN)) && (disp_len <= LEN_W'(MAX_LEN))));
  a_r4_no_key_in_show : assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SHOW) |=> (key_idx_q == '0));
  a_r5_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (res_v_q && !start_req) |=> (res_v_q && $stable(result_q)));
  a_r7_retry : assert property (@(posedge clk) disable iff (!rst_n)
    (entry_bad && !out_of_tries && !start_req) |=> (gen_we && !alarm_q && !res_v_q));
  a_r8_alarm_hold : assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !start_req) |=> (alarm_q && !disp_show));
  a_r8_one_outcome : assert property (@(posedge clk) disable iff (!rst_n)
    !(alarm_q && res_v_q));
  a_r9_start_clears : assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (!res_v_q && !alarm_q && (tries_q == '0) && gen_we));

endmodule

// File: tb/recall_tester_tb_top.sv
`timescale 1ns/1ps
module recall_tester_tb_top;
  localparam int MIN_LEN = 6;
  localparam int MAX_LEN = 12;
  localparam int SHOW_MS = 2000;
  localparam int TRIES   = 3;
  localparam int TIME_W  = 8;
  localparam int LEN_W   = $clog2(MAX_LEN + 1);
  localparam int TMAX    = (1 << TIME_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, start_req = 1'b0, ms_tick = 1'b0, key_valid = 1'b0;
  logic [3:0]           key_digit = 4'h0;
  logic [MAX_LEN*4-1:0] disp_digits;
  logic [LEN_W-1:0]     disp_len;
  logic                 disp_show, result_valid, alarm;
  logic [TIME_W-1:0]    result_ms;

  always #10 clk = ~clk;

  recall_tester #(.MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .SHOW_MS(SHOW_MS),
                  .MAX_TRIES(TRIES), .TIME_W(TIME_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .ms_tick(ms_tick),
    .key_valid(key_valid), .key_digit(key_digit), .disp_digits(disp_digits),
    .disp_len(disp_len), .disp_show(disp_show), .result_valid(result_valid),
    .result_ms(result_ms), .alarm(alarm)
  );

  int n_cmp = 0, n_bad = 0, phase = 0, cur_len = 0, prev_len = 0;
  bit tick_drv = 1'b0, done = 1'b0;
  logic [3:0] cur_pat [MAX_LEN];
  logic [3:0] prev_pat [MAX_LEN];

  function automatic int expect_ms(int ticks);
    return (ticks > TMAX) ? TMAX : ticks;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs after an edge, then wait past the next edge.
  task automatic step(bit kv, logic [3:0] kd, bit st);
    tick_drv  = (phase == 0);
    ms_tick   = tick_drv;
    phase     = (phase + 1) % 2;
    key_valid = kv;
    key_digit = kd;
    start_req = st;
    @(posedge clk);
    #1;
  endtask

  task automatic await_show(string req);
    int guard = 0;
    int junk  = 0;
    while (!disp_show && guard < 100) begin
      step(1'b0, 4'h0, 1'b0);
      guard++;
    end
    check(req, 32'(disp_show), 1);
    cur_len = int'(disp_len);
    for (int i = 0; i < MAX_LEN; i++) begin
      cur_pat[i] = disp_digits[i*4 +: 4];
      if (i >= cur_len && cur_pat[i] != 4'h0) junk++;
    end
    check("R2 length within range", 32'((cur_len >= MIN_LEN) && (cur_len <= MAX_LEN)), 1);
    check("R2 slots past length read zero", 32'(junk), 0);
  endtask

  task automatic run_show(bit noise);
    int t = 0;
    int guard = 0;
    bit kv;
    while (disp_show && guard < SHOW_MS * 4) begin
      kv = noise && ($urandom_range(0, 3) == 0);
      step(kv, 4'($urandom_range(0, 15)), 1'b0);
      if (tick_drv) t++;
      guard++;
    end
    check("R3 display lasts SHOW_MS ticks", 32'(t), SHOW_MS);
    check("R3 blanked digits read zero", 32'((disp_digits == '0) && (disp_len == '0)), 1);
  endtask

  task automatic enter(int bad_pos, int lead, bit align, bit skip_last, output int ticks);
    int gap;
    logic [3:0] d;
    ticks = 0;
    for (int i = 0; i < cur_len; i++) begin
      gap = (i == 0) ? lead : $urandom_range(0, 4);
      for (int g = 0; g < gap; g++) begin
        step(1'b0, 4'h0, 1'b0);
        if (tick_drv) ticks++;
      end
      if (skip_last && i == cur_len - 1) return;
      if (align && i == cur_len - 1)
        while (phase != 0) begin
          step(1'b0, 4'h0, 1'b0);
          if (tick_drv) ticks++;
        end
      d = cur_pat[i];
      if (i == bad_pos) d = d ^ 4'h5;
      step(1'b1, d, 1'b0);
      if (tick_drv) ticks++;
    end
  endtask

  initial begin
    int t;
    int diff;
    logic [TIME_W-1:0] held;
    void'($urandom(32'd4271));
    repeat (4) step(1'b0, 4'h0, 1'b0);
    check("R1 reset show low", 32'(disp_show), 0);
    check("R1 reset result low", 32'(result_valid), 0);
    check("R1 reset alarm low", 32'(alarm), 0);
    check("R1 reset digits zero", 32'((disp_digits == '0) && (disp_len == '0)), 1);
    rst_n = 1'b1;
    repeat (20) step(1'b1, 4'($urandom_range(0, 15)), 1'b0);
    check("R1 idle ignores keys", 32'(disp_show | result_valid | alarm), 0);

    // A: plain correct entry
    step(1'b0, 4'h0, 1'b1);
    await_show("R9 start shows a pattern");
    run_show(1'b1);
    check("R4 no result after keys during display", 32'(result_valid), 0);
    enter(-1, 3, 1'b0, 1'b0, t);
    check("R5 match raises result", 32'(result_valid), 1);
    check("R6 reaction time", 32'(result_ms), 32'(expect_ms(t)));
    held = result_ms;
    repeat (30) step(1'b1, 4'($urandom_range(0, 15)), 1'b0);
    check("R5 result held", 32'(result_valid && (result_ms == held)), 1);
    check("R4 keys after pass ignored", 32'(disp_show | alarm), 0);

    // B: one mismatch then a match with a tick on the final digit
    step(1'b0, 4'h0, 1'b1);
    check("R9 start clears result", 32'(result_valid), 0);
    await_show("R9 new challenge shown");
    run_show(1'b0);
    prev_len = cur_len;
    for (int i = 0; i < MAX_LEN; i++) prev_pat[i] = cur_pat[i];
    enter($urandom_range(0, cur_len - 1), 2, 1'b0, 1'b0, t);
    check("R7 mismatch gives no result", 32'(result_valid | alarm), 0);
    await_show("R7 new pattern after mismatch");
    diff = (prev_len != cur_len) ? 1 : 0;
    for (int i = 0; i < MAX_LEN; i++) if (prev_pat[i] != cur_pat[i]) diff = 1;
    check("R10 successive patterns differ", 32'(diff), 1);
    run_show(1'b1);
    enter(-1, 5, 1'b1, 1'b0, t);
    check("R6 tick coinciding with last digit counted", 32'(result_ms), 32'(expect_ms(t)));
    check("R5 second attempt match", 32'(result_valid), 1);

    // C: three mismatches after a fresh start
    step(1'b0, 4'h0, 1'b1);
    for (int k = 0; k < TRIES; k++) begin
      await_show("R7 pattern for each attempt");
      run_show(1'b0);
      enter($urandom_range(0, cur_len - 1), 1, 1'b0, 1'b0, t);
      if (k < TRIES - 1) check("R9 attempt count cleared, no early alarm", 32'(alarm), 0);
      else check("R8 final mismatch raises alarm", 32'(alarm), 1);
    end
    check("R8 no result with alarm", 32'(result_valid), 0);
    repeat (60) step(1'b1, 4'($urandom_range(0, 15)), 1'b0);
    check("R8 alarm held, no new pattern", 32'(alarm && !disp_show), 1);
    step(1'b0, 4'h0, 1'b1);
    check("R9 start clears alarm", 32'(alarm), 0);
    await_show("R9 challenge after alarm");
    run_show(1'b0);
    enter(-1, 600, 1'b0, 1'b0, t);
    check("R6 ticks exceed counter range", 32'(t > TMAX), 1);
    check("R6 saturated reaction time", 32'(result_ms), TMAX);

    // D: start pulse in the same cycle as the final digit
    step(1'b0, 4'h0, 1'b1);
    await_show("R9 challenge for priority test");
    run_show(1'b0);
    enter(-1, 2, 1'b0, 1'b1, t);
    check("R5 not judged before last digit", 32'(result_valid), 0);
    step(1'b1, cur_pat[cur_len - 1], 1'b1);
    check("R9 start beats final digit", 32'(result_valid), 0);
    await_show("R9 fresh pattern after start");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (R1..R10 flow hung): actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule